// File: doc/BRIEF.md
# Lease-Timed Private Cache

This block is the private data cache that sits beside one core in a many-core system whose coherence rests on leases instead of invalidation messages. A shared line that arrives from its home library brings an expiry stamp with it. The cache stores that stamp with the line's tag and data. A load hits only while the free-running global time input has not moved past the stored stamp. Once time moves past the stamp, the line is simply no longer usable, so there is no invalidation input and no state bit to clear.

Loads that miss, or that find the lease lapsed, send a read to the library and install the returned line together with its new stamp. A response whose stamp has already lapsed when it arrives still completes the load, but it is not installed. Stores and atomic read-modify-writes are never applied to the local copy. They travel to the library with their data, and the core waits for the acknowledgement.

Addresses whose home field names this core's own library slice bypass the lease logic entirely. The cache is direct-mapped and handles one outstanding library transaction at a time.

Top module: `lease_cache`

## Requirements
- R1: After reset the cache holds no usable line, `core_req_ready` is 1, and `core_rsp_valid` and `lib_req_valid` are 0.
- R2: A load (op code 0) to a non-home address whose line is present with a matching tag and whose stored expiry is not less than `now` is answered on the cycle after acceptance with the cached word, and no library request is made.
- R3: The lease check is inclusive: `now` equal to the stored expiry still hits, and `now` one greater misses and refetches from the library.
- R4: A load miss issues exactly one library request of kind 0 carrying the requested word address. The core receives the addressed word of the returned line on the cycle after `lib_rsp_valid`.
- R5: A returned line is installed only if `lib_rsp_expiry` is not less than `now` in the response cycle. The load completes with the returned word either way.
- R6: An address whose top HOME_W bits equal MY_HOME is always sent to the library, is never installed, and its returned word reaches the core regardless of the returned expiry.
- R7: A store (op code 1) is forwarded as kind 1 with its data. The core gets a response (data 0) only on the cycle after the acknowledgement. A live cached copy of the line keeps its old contents.
- R8: A read-modify-write (op code 2) is forwarded as kind 2 with its data, and the core receives the addressed word of the acknowledgement line (the old value).
- R9: From acceptance of a miss, store or read-modify-write until its response, `core_req_ready` is 0.
- R10: The cache is direct-mapped on word-address bits above the word offset. A load to a different tag at the same index replaces the line, so the earlier line misses afterwards.
- R11: While `lib_req_ready` is low, `lib_req_valid` stays high and the request kind, address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TS_W | Global time |
| core_req_valid | input | 1 | Core request present |
| core_req_op | input | 2 | 0 load, 1 store, 2 read-modify-write |
| core_req_addr | input | ADDR_W | Word address |
| core_req_wdata | input | WORD_W | Store or read-modify-write data |
| core_req_ready | output | 1 | Cache can accept a request |
| core_rsp_valid | output | 1 | Response to the core, one cycle |
| core_rsp_data | output | WORD_W | Load or old word, 0 for stores |
| lib_req_valid | output | 1 | Library request present |
| lib_req_kind | output | 2 | Same coding as core_req_op |
| lib_req_addr | output | ADDR_W | Word address sent to the library |
| lib_req_wdata | output | WORD_W | Write data sent to the library |
| lib_req_ready | input | 1 | Library takes the request |
| lib_rsp_valid | input | 1 | Library reply or acknowledgement, one cycle |
| lib_rsp_line | input | WORD_W*WORDS | Full line, word 0 in the low bits |
| lib_rsp_expiry | input | TS_W | Lease end stamp for the line |

## Verification
The bench builds the cache with four lines of four 16-bit words, a 12-bit word address, a 16-bit time and a 2-bit home field with this core at slot 3. With these values, two addresses 0x100 apart collide on one index, and every address from 0xC00 upward is home. Setting the global time by hand puts a load exactly on the expiry stamp and one tick past it. A library model that hands out negative lease lengths produces responses that are already stale on arrival.

// File: rtl/lease_pkg.sv
package lease_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_RMW   = 2'd2
    } lease_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/lease_word_pick.sv
module lease_word_pick #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 16,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic [WORD_W*WORDS-1:0] line,
    input  logic [OFF_W-1:0]        off,
    output logic [WORD_W-1:0]       word
);
    logic [WORD_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = line[g*WORD_W +: WORD_W];
    end

    assign word = words[off];
endmodule

// File: rtl/lease_line_store.sv
module lease_line_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 16,
    parameter int LINE_W = 512,
    parameter int TS_W   = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [TS_W-1:0]   wr_exp,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    output logic [TS_W-1:0]   rd_exp
);
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] line;
        logic [TS_W-1:0]   exp;
    } ent_t;

    ent_t ent_q [LINES];
    ent_t ent_d [LINES];

    // A refill replaces tag, data and stamp of one index at once.
    always_comb begin
        ent_d = ent_q;
        if (wr_en) begin
            ent_d[wr_idx] = '{vld: 1'b1, tag: wr_tag, line: wr_line, exp: wr_exp};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            ent_q <= ent_d;
        end
    end

    assign rd_vld  = ent_q[rd_idx].vld;
    assign rd_tag  = ent_q[rd_idx].tag;
    assign rd_line = ent_q[rd_idx].line;
    assign rd_exp  = ent_q[rd_idx].exp;
endmodule

// File: rtl/lease_probe.sv
module lease_probe #(
    parameter int TAG_W  = 16,
    parameter int WORD_W = 32,
    parameter int WORDS  = 16,
    parameter int TS_W   = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic [TS_W-1:0]         now,
    input  logic [TAG_W-1:0]        req_tag,
    input  logic [OFF_W-1:0]        req_off,
    input  logic                    ent_vld,
    input  logic [TAG_W-1:0]        ent_tag,
    input  logic [WORD_W*WORDS-1:0] ent_line,
    input  logic [TS_W-1:0]         ent_exp,
    output logic                    hit,
    output logic [WORD_W-1:0]       word
);
    // The lease is live up to and including the stamp; no stored bit tracks it.
    assign hit = ent_vld && (ent_tag == req_tag) && (now <= ent_exp);

    lease_word_pick #(.WORD_W(WORD_W), .WORDS(WORDS)) u_pick (
        .line (ent_line),
        .off  (req_off),
        .word (word)
    );
endmodule

// File: rtl/lease_cache.sv
module lease_cache
    import lease_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 16,
    parameter int LINES   = 16,
    parameter int TS_W    = 32,
    parameter int HOME_W  = 4,
    parameter int MY_HOME = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TS_W-1:0]         now,
    input  logic                    core_req_valid,
    input  logic [1:0]              core_req_op,
    input  logic [ADDR_W-1:0]       core_req_addr,
    input  logic [WORD_W-1:0]       core_req_wdata,
    output logic                    core_req_ready,
    output logic                    core_rsp_valid,
    output logic [WORD_W-1:0]       core_rsp_data,
    output logic                    lib_req_valid,
    output logic [1:0]              lib_req_kind,
    output logic [ADDR_W-1:0]       lib_req_addr,
    output logic [WORD_W-1:0]       lib_req_wdata,
    input  logic                    lib_req_ready,
    input  logic                    lib_rsp_valid,
    input  logic [WORD_W*WORDS-1:0] lib_rsp_line,
    input  logic [TS_W-1:0]         lib_rsp_expiry
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = WORD_W * WORDS;

    typedef struct packed {
        ctl_state_e        st;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic              home;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_d;
    } ctl_t;

    ctl_t q, d;

    // Address fields of the incoming request and of the pending one.
    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             req_home;
    logic [OFF_W-1:0] pend_off;
    logic [IDX_W-1:0] pend_idx;
    logic [TAG_W-1:0] pend_tag;

    assign req_off  = core_req_addr[OFF_W-1:0];
    assign req_idx  = core_req_addr[OFF_W +: IDX_W];
    assign req_tag  = core_req_addr[ADDR_W-1 -: TAG_W];
    assign req_home = (core_req_addr[ADDR_W-1 -: HOME_W] == HOME_W'(MY_HOME));
    assign pend_off = q.addr[OFF_W-1:0];
    assign pend_idx = q.addr[OFF_W +: IDX_W];
    assign pend_tag = q.addr[ADDR_W-1 -: TAG_W];

    logic              ent_vld;
    logic [TAG_W-1:0]  ent_tag;
    logic [LINE_W-1:0] ent_line;
    logic [TS_W-1:0]   ent_exp;
    logic              hit;
    logic [WORD_W-1:0] hit_word;
    logic [WORD_W-1:0] rsp_word;
    logic              wr_en;

    lease_line_store #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .LINE_W(LINE_W),
        .TS_W  (TS_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (pend_idx),
        .wr_tag  (pend_tag),
        .wr_line (lib_rsp_line),
        .wr_exp  (lib_rsp_expiry),
        .rd_idx  (req_idx),
        .rd_vld  (ent_vld),
        .rd_tag  (ent_tag),
        .rd_line (ent_line),
        .rd_exp  (ent_exp)
    );

    lease_probe #(
        .TAG_W (TAG_W),
        .WORD_W(WORD_W),
        .WORDS (WORDS),
        .TS_W  (TS_W)
    ) u_probe (
        .now      (now),
        .req_tag  (req_tag),
        .req_off  (req_off),
        .ent_vld  (ent_vld),
        .ent_tag  (ent_tag),
        .ent_line (ent_line),
        .ent_exp  (ent_exp),
        .hit      (hit),
        .word     (hit_word)
    );

    lease_word_pick #(.WORD_W(WORD_W), .WORDS(WORDS)) u_rsp_pick (
        .line (lib_rsp_line),
        .off  (pend_off),
        .word (rsp_word)
    );

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        wr_en   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (core_req_valid) begin
                    if ((core_req_op == OP_LOAD) && !req_home && hit) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = hit_word;
                    end else begin
                        d.st    = ST_REQ;
                        d.op    = core_req_op;
                        d.addr  = core_req_addr;
                        d.wdata = core_req_wdata;
                        d.home  = req_home;
                    end
                end
            end
            ST_REQ: begin
                if (lib_req_ready) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (lib_rsp_valid) begin
                    d.st    = ST_IDLE;
                    d.rsp_v = 1'b1;
                    d.rsp_d = (q.op == OP_STORE) ? '0 : rsp_word;
                    // Stale-on-arrival and home lines complete but are not kept.
                    wr_en   = (q.op == OP_LOAD) && !q.home && (lib_rsp_expiry >= now);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign core_req_ready = (q.st == ST_IDLE);
    assign core_rsp_valid = q.rsp_v;
    assign core_rsp_data  = q.rsp_d;
    assign lib_req_valid  = (q.st == ST_REQ);
    assign lib_req_kind   = q.op;
    assign lib_req_addr   = q.addr;
    assign lib_req_wdata  = q.wdata;
endmodule

// File: rtl/lease_cache_chk.sv
module lease_cache_chk #(
    parameter int ADDR_W = 24,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_req_valid,
    input logic [1:0]        core_req_op,
    input logic              core_req_ready,
    input logic              core_rsp_valid,
    input logic              lib_req_valid,
    input logic              lib_req_ready,
    input logic [1:0]        lib_req_kind,
    input logic [ADDR_W-1:0] lib_req_addr,
    input logic [WORD_W-1:0] lib_req_wdata,
    input logic              lib_rsp_valid
);
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> core_req_ready && !core_rsp_valid && !lib_req_valid);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lib_req_valid && !lib_req_ready |=> lib_req_valid && $stable(lib_req_kind)
            && $stable(lib_req_addr) && $stable(lib_req_wdata));

    a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        core_req_valid && core_req_ready && (core_req_op != 2'd0) |=> !core_req_ready);

    a_r7_write_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
        core_req_valid && core_req_ready && (core_req_op != 2'd0) |=> lib_req_valid);

    a_r7_ack_answers: assert property (@(posedge clk) disable iff (!rst_n)
        lib_rsp_valid |=> core_rsp_valid);

    a_r2_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        core_rsp_valid |-> $past(lib_rsp_valid) || $past(core_req_valid && core_req_ready));
endmodule

bind lease_cache lease_cache_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_req_valid (core_req_valid),
    .core_req_op    (core_req_op),
    .core_req_ready (core_req_ready),
    .core_rsp_valid (core_rsp_valid),
    .lib_req_valid  (lib_req_valid),
    .lib_req_ready  (lib_req_ready),
    .lib_req_kind   (lib_req_kind),
    .lib_req_addr   (lib_req_addr),
    .lib_req_wdata  (lib_req_wdata),
    .lib_rsp_valid  (lib_rsp_valid)
);

// File: tb/sim_lease_cache.sv
`timescale 1ns/1ps
module sim_lease_cache;
    localparam int AW = 12;
    localparam int WW = 16;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   now = 16'd0;
    logic          core_req_valid = 1'b0;
    logic [1:0]    core_req_op = 2'd0;
    logic [AW-1:0] core_req_addr = '0;
    logic [WW-1:0] core_req_wdata = '0;
    logic          core_req_ready;
    logic          core_rsp_valid;
    logic [WW-1:0] core_rsp_data;
    logic          lib_req_valid;
    logic [1:0]    lib_req_kind;
    logic [AW-1:0] lib_req_addr;
    logic [WW-1:0] lib_req_wdata;
    logic          lib_req_ready = 1'b0;
    logic          lib_rsp_valid = 1'b0;
    logic [WW*NW-1:0] lib_rsp_line = '0;
    logic [15:0]   lib_rsp_expiry = '0;

    lease_cache #(
        .ADDR_W(AW), .WORD_W(WW), .WORDS(NW), .LINES(4),
        .TS_W(16), .HOME_W(2), .MY_HOME(3)
    ) u0 (.*);

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Library model: word contents, lease length and request log.
    logic [WW-1:0] mem [int];
    int            lease = 10;
    int            lib_cnt = 0;
    logic [1:0]    last_kind;
    logic [AW-1:0] last_addr;
    logic [WW-1:0] last_wdata;

    function automatic logic [WW-1:0] mw(input int a);
        if (mem.exists(a)) return mem[a];
        return WW'(a * 7 + 3);
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && lib_req_valid) begin
                last_kind  = lib_req_kind;
                last_addr  = lib_req_addr;
                last_wdata = lib_req_wdata;
                repeat (2) begin
                    @(negedge clk);
                    chk(lib_req_valid && lib_req_addr == last_addr && lib_req_kind == last_kind
                        && lib_req_wdata == last_wdata, "R11", "request held while not ready",
                        lib_req_addr, last_addr);
                end
                lib_req_ready = 1'b1;
                @(negedge clk);
                lib_req_ready = 1'b0;
                lib_cnt++;
                @(negedge clk);
                for (int i = 0; i < NW; i++) begin
                    lib_rsp_line[i*WW +: WW] = mw((int'(last_addr) & ~3) + i);
                end
                if (last_kind != 2'd0) mem[int'(last_addr)] = last_wdata;
                lib_rsp_expiry = 16'(int'(now) + lease);
                lib_rsp_valid = 1'b1;
                @(negedge clk);
                lib_rsp_valid = 1'b0;
            end
        end
    end

    // Scoreboard monitor.
    logic [WW-1:0] exp_q [$];
    string         tag_q [$];
    int            rsp_cnt = 0;

    initial begin
        logic [WW-1:0] e;
        string t;
        forever begin
            @(negedge clk);
            if (rst_n && core_rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "response with none expected", core_rsp_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(core_rsp_data == e, t, "response data", core_rsp_data, e);
                end
                rsp_cnt++;
            end
        end
    end

    task automatic access(input logic [1:0] op, input logic [AW-1:0] a, input logic [WW-1:0] wd,
                          input logic [WW-1:0] ed, input int dlib, input string rq);
        int c0 = rsp_cnt;
        int l0 = lib_cnt;
        exp_q.push_back(ed);
        tag_q.push_back(rq);
        @(negedge clk);
        core_req_valid = 1'b1;
        core_req_op    = op;
        core_req_addr  = a;
        core_req_wdata = wd;
        while (!core_req_ready) @(negedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        if (dlib != 0) chk(!core_req_ready, "R9", "ready while pending", core_req_ready, 0);
        while (rsp_cnt == c0) @(posedge clk);
        chk(lib_cnt - l0 == dlib, rq, "library request count", lib_cnt - l0, dlib);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [WW-1:0] old;
        repeat (3) @(negedge clk);
        chk(core_req_ready && !core_rsp_valid && !lib_req_valid, "R1", "reset outputs",
            {core_req_ready, core_rsp_valid, lib_req_valid}, 3'b100);
        rst_n = 1'b1;
        now = 16'd100;

        // Miss, then hits inside the lease, then the edge of the lease.
        access(2'd0, 12'h011, '0, mw(12'h011), 1, "R4");
        chk(last_kind == 2'd0 && last_addr == 12'h011, "R4", "read request fields",
            last_addr, 12'h011);
        now = 16'd105;
        access(2'd0, 12'h012, '0, mw(12'h012), 0, "R2");
        now = 16'd110;
        access(2'd0, 12'h013, '0, mw(12'h013), 0, "R3");
        now = 16'd111;
        access(2'd0, 12'h010, '0, mw(12'h010), 1, "R3");

        // Store leaves the live cached copy untouched.
        now = 16'd112;
        old = mw(12'h011);
        access(2'd1, 12'h011, 16'hBEEF, 16'h0000, 1, "R7");
        chk(last_kind == 2'd1 && last_wdata == 16'hBEEF, "R7", "store request fields",
            last_wdata, 16'hBEEF);
        now = 16'd113;
        access(2'd0, 12'h011, '0, old, 0, "R7");

        // Read-modify-write returns the old word.
        access(2'd2, 12'h012, 16'h1234, mw(12'h012), 1, "R8");
        chk(last_kind == 2'd2 && last_wdata == 16'h1234, "R8", "rmw request fields",
            last_wdata, 16'h1234);

        // Same index, other tag, evicts the first line.
        now = 16'd114;
        access(2'd0, 12'h111, '0, mw(12'h111), 1, "R10");
        access(2'd0, 12'h011, '0, 16'hBEEF, 1, "R10");

        // Stale on arrival: completes but is not kept.
        now = 16'd130;
        lease = -1;
        access(2'd0, 12'h024, '0, mw(12'h024), 1, "R5");
        access(2'd0, 12'h025, '0, mw(12'h025), 1, "R5");
        lease = 20;
        access(2'd0, 12'h024, '0, mw(12'h024), 1, "R5");
        access(2'd0, 12'h026, '0, mw(12'h026), 0, "R5");

        // Home addresses always go to the library.
        lease = 50;
        access(2'd0, 12'hC14, '0, mw(12'hC14), 1, "R6");
        access(2'd0, 12'hC14, '0, mw(12'hC14), 1, "R6");
        lease = -5;
        access(2'd0, 12'hC15, '0, mw(12'hC15), 1, "R6");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule